// File: doc/BRIEF.md
# Write-Only I2C Configuration Register Slave

This block is an I2C target that only accepts writes. A bus master uses it to load a small bank of byte-wide configuration registers. The block samples both bus lines with its own system clock. It spots START and STOP conditions. It then checks the first byte after a START against a fixed device address.

When the address matches, the next byte is a subaddress. Its top bit selects one of two modes:

- **Single-register mode:** every data byte that follows rewrites one register.
- **Auto-increment mode:** the data bytes walk through consecutive registers. The 4-bit pointer visits all sixteen codes and wraps, but only codes 0 to 9 hold storage.

Every stored byte raises a one-cycle write strobe that carries the register index. The whole bank is also visible at all times as one flat parallel output.

The block drives the bus only through an open-drain acknowledge enable. The surrounding logic ties that enable to a pull-down on SDA.

Top module: `i2c_cfg_slave`

## Requirements
- R1: A START is SDA falling while SCL is high. A START moves the block to address reception from any state. A STOP is SDA rising while SCL is high. A STOP returns the block to idle.
- R2: On the ninth clock of every accepted address, subaddress or data byte, the block asserts `sda_oe`, which pulls SDA low. `sda_oe` changes only while the synchronized SCL is low.
- R3: Only the address byte 0x80 is accepted. This is 7-bit address 0x40 with the write bit (bit 0) clear. Any other byte, 0x81 included, gets no acknowledge. After such a byte the bus is ignored until the next START, so no further bytes are acknowledged or stored.
- R4: In the subaddress byte:
  - bits [3:0] give the starting register;
  - bit 7 = 1 selects auto-increment;
  - bits [6:4] have no effect.
- R5: With subaddress bit 7 = 0, every data byte up to STOP is written to the same register. The last byte written is the one that remains.
- R6: With subaddress bit 7 = 1, data byte k goes to pointer (start + k) mod 16. The pointer wraps from 15 to 0.
- R7: A data byte whose pointer is 10 to 15 is acknowledged but not stored, and it produces no strobe.
- R8: Each stored byte gives `wr_stb` high for exactly one cycle, with `wr_idx` equal to the register written. `regs_o` changes only in a cycle where `wr_stb` is high.
- R9: A START that arrives in the middle of a data byte discards the partial byte, so nothing is written. Reception then restarts with the address byte.
- R10: After reset every register is 0x00. `atten_o` always equals bits [5:0] of register 0, which hold the attenuation step count in 0.5 dB units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both bus lines are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | High pulls SDA low (acknowledge) |
| wr_stb | output | 1 | One-cycle pulse per stored byte |
| wr_idx | output | 4 | Register index of the current store |
| atten_o | output | 6 | Attenuation step count from register 0 |
| regs_o | output | NUM_REGS*8 | Register bank; register i is at bits [8i+7:8i] |

## Verification
A wrong pointer or wrong mode bit appears as a register holding the wrong byte once the transfer's STOP has passed. It also shows earlier, as a strobe index that breaks the expected sequence on the very next stored byte. A bit counter that is off by one shifts the acknowledge window, and the master sees this on the ninth clock of the same byte. A state machine that fails to fall back to idle shows up as an acknowledge or a strobe where none should appear, on the byte after a rejected address or after a STOP.

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave #(
  parameter logic [7:0] DEV_ADDR = 8'h80,
  parameter int NUM_REGS = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic                  wr_stb,
  output logic [3:0]            wr_idx,
  output logic [5:0]            atten_o,
  output logic [NUM_REGS*8-1:0] regs_o
);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_SUB, ST_DATA} st_t;

  logic [1:0] scl_m, sda_m;
  logic       scl_p, sda_p;
  logic       scl_n, sda_n;
  st_t        st;
  logic [3:0] bcnt;
  logic [7:0] shreg;
  logic [3:0] ptr;
  logic       inc;
  logic [7:0] rf [NUM_REGS];

  assign scl_n = scl_m[1];
  assign sda_n = sda_m[1];

  wire start_c = scl_n & scl_p & sda_p & ~sda_n;
  wire stop_c  = scl_n & scl_p & ~sda_p & sda_n;
  wire rise_c  = scl_n & ~scl_p;
  wire fall_c  = ~scl_n & scl_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 2'b11;
      sda_m <= 2'b11;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_m <= {scl_m[0], scl_i};
      sda_m <= {sda_m[0], sda_i};
      scl_p <= scl_n;
      sda_p <= sda_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      bcnt   <= '0;
      shreg  <= '0;
      ptr    <= '0;
      inc    <= 1'b0;
      sda_oe <= 1'b0;
      wr_stb <= 1'b0;
      wr_idx <= '0;
      for (int i = 0; i < NUM_REGS; i++) rf[i] <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_c) begin
        st     <= ST_ADDR;
        bcnt   <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= ST_IDLE;
        bcnt   <= '0;
        sda_oe <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (rise_c && bcnt < 4'd8) begin
          shreg <= {shreg[6:0], sda_n};
          bcnt  <= bcnt + 4'd1;
        end else if (fall_c && bcnt == 4'd8) begin
          bcnt <= 4'd9;
          case (st)
            ST_ADDR: begin
              if (shreg == DEV_ADDR) begin
                sda_oe <= 1'b1;
                st     <= ST_SUB;
              end else begin
                st   <= ST_IDLE;
                bcnt <= '0;
              end
            end
            ST_SUB: begin
              sda_oe <= 1'b1;
              ptr    <= shreg[3:0];
              inc    <= shreg[7];
              st     <= ST_DATA;
            end
            default: begin
              sda_oe <= 1'b1;
              if (int'(ptr) < NUM_REGS) begin
                rf[ptr] <= shreg;
                wr_stb  <= 1'b1;
                wr_idx  <= ptr;
              end
              if (inc) ptr <= ptr + 4'd1;
            end
          endcase
        end else if (fall_c && bcnt == 4'd9) begin
          sda_oe <= 1'b0;
          bcnt   <= '0;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_o[g*8 +: 8] = rf[g];
  end

  assign atten_o = rf[0][5:0];

  AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_n);  // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);  // R3
  AST_STB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (int'(wr_idx) < NUM_REGS));  // R7
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);  // R8
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> $stable(regs_o));  // R8

endmodule

// File: tb/i2c_cfg_slave_test.sv
module i2c_cfg_slave_test;
  localparam int CLK_PER = 10;
  localparam int Q = 6;
  localparam int NR = 10;

  logic clk = 0, rst_n = 0;
  logic scl = 1, m_low = 0;
  logic sda_oe, wr_stb;
  logic [3:0] wr_idx;
  logic [5:0] atten_o;
  logic [NR*8-1:0] regs_o;
  wire sda = ~(m_low | sda_oe);

  i2c_cfg_slave #(.DEV_ADDR(8'h80), .NUM_REGS(NR)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .wr_idx(wr_idx), .atten_o(atten_o), .regs_o(regs_o));

  always #(CLK_PER/2) clk = ~clk;

  int total = 0, bad = 0, n_stb = 0;
  int slog [64];
  int exp_r [16];

  always @(posedge clk) if (wr_stb) begin
    if (n_stb < 64) slog[n_stb] = int'(wr_idx);
    n_stb++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic m_start();
    m_low = 0; qw(); scl = 1; qw(); m_low = 1; qw(); scl = 0; qw();
  endtask

  task automatic m_stop();
    m_low = 1; qw(); scl = 1; qw(); m_low = 0; qw(); qw();
  endtask

  task automatic m_bit(input bit b);
    m_low = ~b; qw(); scl = 1; qw(); qw(); scl = 0; qw();
  endtask

  task automatic m_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) m_bit(b[i]);
    m_low = 0; qw(); scl = 1; qw(); ack = (sda == 1'b0); qw(); scl = 0; qw();
  endtask

  task automatic chk_bank(input string req);
    for (int i = 0; i < NR; i++)
      chk(regs_o[i*8 +: 8] == exp_r[i][7:0], req, int'(regs_o[i*8 +: 8]), exp_r[i]);
    chk(atten_o == exp_r[0][5:0], "R10 atten", int'(atten_o), exp_r[0] & 63);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit a;
    int cnt;
    for (int i = 0; i < 16; i++) exp_r[i] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 0, "R10 reset sda_oe", int'(sda_oe), 0);
    chk_bank("R10 reset");

    // R4 R6 R7 R8: auto-increment sweep over every start pointer, 17 bytes each (wraps)
    for (int s = 0; s < 16; s++) begin
      logic [7:0] sub;
      sub = 8'h80 | 8'(s) | ((s % 2) ? 8'h50 : 8'h00);
      n_stb = 0; cnt = 0;
      m_start();
      m_byte(8'h80, a); chk(a, "R2 addr ack", int'(a), 1);
      m_byte(sub, a);   chk(a, "R2 sub ack", int'(a), 1);
      for (int k = 0; k < 17; k++) begin
        int p, v;
        p = (s + k) % 16;
        v = (s * 17 + k * 5 + 3) % 256;
        m_byte(8'(v), a);
        chk(a, "R7 data ack", int'(a), 1);
        if (p < NR) begin
          exp_r[p] = v;
          if (cnt < 64) chk(slog[cnt] == p, "R8 strobe idx", slog[cnt], p);
          cnt++;
        end
      end
      m_stop();
      chk(n_stb == cnt, "R7 strobe count", n_stb, cnt);
      chk_bank("R6 inc bank");
    end

    // R4 R5 R7: single-register mode sweep, three bytes each
    for (int r = 0; r < 16; r++) begin
      logic [7:0] sub;
      sub = 8'(r) | 8'((r * 16) & 8'h70);
      n_stb = 0;
      m_start();
      m_byte(8'h80, a); m_byte(sub, a);
      for (int k = 0; k < 3; k++) begin
        m_byte(8'((r * 29 + k * 71 + 9) % 256), a);
        chk(a, "R2 data ack", int'(a), 1);
      end
      m_stop();
      if (r < NR) exp_r[r] = (r * 29 + 2 * 71 + 9) % 256;
      chk(n_stb == (r < NR ? 3 : 0), "R5 strobe count", n_stb, r < NR ? 3 : 0);
      if (r < NR && n_stb == 3)
        chk(slog[0] == r && slog[2] == r, "R5 same idx", slog[2], r);
      chk_bank("R5 single bank");
    end

    // R3: wrong addresses are not acknowledged and the rest of the transfer is ignored
    n_stb = 0;
    m_start();
    m_byte(8'h82, a); chk(!a, "R3 nack 0x82", int'(a), 0);
    m_byte(8'h01, a); chk(!a, "R3 ignored sub", int'(a), 0);
    m_byte(8'h55, a); chk(!a, "R3 ignored data", int'(a), 0);
    m_stop();
    m_start();
    m_byte(8'h81, a); chk(!a, "R3 nack 0x81", int'(a), 0);
    m_byte(8'h00, a); m_byte(8'h77, a);
    m_stop();
    chk(n_stb == 0, "R3 no strobe", n_stb, 0);
    chk_bank("R3 bank unchanged");

    // R1: bytes after STOP without a START are ignored
    m_byte(8'h80, a); chk(!a, "R1 idle after stop", int'(a), 0);
    m_byte(8'h02, a); m_byte(8'h99, a);
    chk(n_stb == 0, "R1 no strobe idle", n_stb, 0);
    chk_bank("R1 bank idle");

    // R9: repeated START in the middle of a data byte
    n_stb = 0;
    m_start();
    m_byte(8'h80, a); m_byte(8'h05, a);
    for (int i = 0; i < 4; i++) m_bit(1'b1);
    m_start();
    m_byte(8'h80, a); chk(a, "R1 restart addr ack", int'(a), 1);
    m_byte(8'h06, a); m_byte(8'h22, a);
    m_stop();
    exp_r[6] = 8'h22;
    chk(n_stb == 1, "R9 one strobe", n_stb, 1);
    chk_bank("R9 partial discarded");

    // R10: attenuation field from register 0
    m_start();
    m_byte(8'h80, a); m_byte(8'h00, a); m_byte(8'hFF, a);
    m_stop();
    exp_r[0] = 8'hFF;
    chk(atten_o == 6'd63, "R10 atten max", int'(atten_o), 63);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule